// File: doc/BRIEF.md
# Instruction-Boundary Event Priority Arbiter

This block decides, once per instruction boundary, which pending asynchronous event the core services next. The core raises a one-cycle boundary strobe when an instruction retires and presents the current pending and mask flags together with its control state. This state is the maskable-interrupt enable, the single-step flag, the global interrupt gate, the debug-trap hits of the retiring instruction, and any interrupt shadow that the retiring instruction creates. One cycle after the strobe, the arbiter returns a one-hot grant naming a single event group. With the grant it returns pulses that clear or mask the serviced source, and the fixed vector when the grant is the non-maskable interrupt.

The arbiter holds two pieces of state between boundaries. The first is a 16-bit debug-trap word, which collects trap hits, discards them when the gate is closed, and schedules a single-step trap. The second is a one-bit shadow history, which stops two consecutive stack-segment loads from extending the shadow. At every boundary the arbiter also recomputes a summary bit that tells the core whether anything remains that needs another pass through the event path. Fetching the interrupt vector from an interrupt controller and delivering exceptions are left to the surrounding logic.

Top module: `evt_boundary_arb`

## Requirements
- R1: While reset is asserted and after it is released, before any boundary, every grant bit, the vector, all pulse outputs, the summary bit and the trap word read zero.
- R2: A grant is issued only in the cycle that follows a cycle with the boundary strobe high. At most one grant bit is set. All grant, vector and pulse outputs are zero in every other cycle.
- R3: Grant bits, from highest priority to lowest, are: 0 task-switch trap, 1 SMI, 2 INIT, 3 debug trap, 4 NMI, 5 local-controller interrupt, 6 external maskable interrupt, 7 virtual interrupt, 8 DMA hold. The highest-priority eligible group is granted.
- R4: SMI and INIT are eligible only when pending, unmasked and the global gate is high. An SMI grant is accompanied by a one-cycle SMI clear pulse.
- R5: An unmasked pending NMI grant is accompanied by an NMI clear pulse, an NMI mask-set pulse and a vector of 2. A masked NMI is never granted.
- R6: Local-controller and external interrupts need the interrupt-enable flag. When both are pending, the local-controller interrupt wins.
- R7: A shadow loaded at a boundary applies to that boundary only. Category bit 0 blocks groups 4 to 8 and category bit 1 blocks group 3. Groups 4 to 8 are also blocked whenever the gate is low.
- R8: A stack-segment-load shadow is not armed when the previous boundary armed one. A third consecutive load arms again.
- R9: With the gate low, every trap bit except bit 14 (single step) is dropped at the boundary, so the trap word then holds at most bit 14.
- R10: If the single-step flag is high at a boundary and the grant is not group 0, 1, 2 or 3, bit 14 is set in the trap word.
- R11: Trap bits 15 (task switch) and 14 to 12 (single step, data and code breakpoints) raise grant 0 or 3. A granted trap word is consumed. The word is retained under a debug shadow or an SMI or INIT grant, and is otherwise cleared.
- R12: The summary bit, updated at each boundary, is high exactly when the new trap word is nonzero, or the DMA hold is requested, or the gate is high and an unmasked event other than the one just granted is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bnd_i | input | 1 | Instruction-boundary strobe |
| gate_i | input | 1 | Global interrupt gate |
| if_i | input | 1 | Maskable-interrupt enable flag |
| tf_i | input | 1 | Single-step flag |
| smi_pend_i | input | 1 | SMI pending |
| smi_mask_i | input | 1 | SMI masked |
| init_pend_i | input | 1 | INIT pending |
| init_mask_i | input | 1 | INIT masked |
| nmi_pend_i | input | 1 | NMI pending |
| nmi_mask_i | input | 1 | NMI masked |
| lint_pend_i | input | 1 | Local-controller interrupt pending |
| ext_pend_i | input | 1 | External maskable interrupt pending |
| virt_pend_i | input | 1 | Virtual interrupt pending |
| dma_req_i | input | 1 | DMA hold request |
| trap_hit_i | input | TRAP_W | Trap bits raised by the retiring instruction |
| shd_load_i | input | 1 | Retiring instruction creates a shadow |
| shd_cat_i | input | 2 | Shadow category: bit 0 interrupts, bit 1 debug |
| shd_ss_i | input | 1 | Shadow comes from a stack-segment load |
| gnt_o | output | 9 | One-hot service grant |
| vec_o | output | VEC_W | Vector for the NMI grant, else zero |
| smi_clr_o | output | 1 | Clear SMI pending |
| nmi_clr_o | output | 1 | Clear NMI pending |
| nmi_mask_set_o | output | 1 | Set NMI mask |
| pend_o | output | 1 | Events still pending |
| trap_word_o | output | TRAP_W | Current debug-trap word |

## Verification
The bench builds the block with its default parameters, a 16-bit trap word, an 8-bit vector and an NMI vector of 2, so that bit positions 15 to 12 and the vector value can be checked literally. With thirteen single-bit event, mask and flag inputs plus a shadow-load bit, a 14-bit sweep visits every combination of them. Hashed trap hits and shadow categories are overlaid on the sweep, which brings every priority crossing, every gating combination and the interplay of the carried trap word and shadow history within reach. Directed sequences before the sweep walk through the shadow chaining rule, the single-step scheduling and the summary corner cases step by step.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;
  // Grant indices in descending priority.
  localparam int unsigned G_TSW  = 0;
  localparam int unsigned G_SMI  = 1;
  localparam int unsigned G_INIT = 2;
  localparam int unsigned G_DBG  = 3;
  localparam int unsigned G_NMI  = 4;
  localparam int unsigned G_LINT = 5;
  localparam int unsigned G_EXT  = 6;
  localparam int unsigned G_VIRT = 7;
  localparam int unsigned G_DMA  = 8;
  localparam int unsigned NGRP   = 9;

  // Shadow category bits.
  typedef struct packed {
    logic dbg;
    logic intr;
  } shd_cat_t;
endpackage

// File: rtl/evt_shadow_trk.sv
module evt_shadow_trk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bnd_i,
  input  logic       load_i,
  input  logic [1:0] cat_i,
  input  logic       ss_i,
  output logic       int_blk_o,
  output logic       dbg_blk_o
);
  import evt_arb_pkg::*;

  shd_cat_t cat;
  logic     armed;
  logic     ss_prev_q, ss_prev_d;

  always_comb begin
    cat       = shd_cat_t'(cat_i);
    // a stack-segment shadow does not re-arm on top of another one
    armed     = load_i & ~(ss_i & ss_prev_q);
    int_blk_o = armed & cat.intr;
    dbg_blk_o = armed & cat.dbg;
    ss_prev_d = bnd_i ? (armed & ss_i) : ss_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_prev_q <= 1'b0;
    else        ss_prev_q <= ss_prev_d;
  end
endmodule

// File: rtl/evt_trap_word.sv
module evt_trap_word #(
  parameter int TRAP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_i,
  input  logic [TRAP_W-1:0] hit_i,
  input  logic              gate_i,
  input  logic              tf_i,
  input  logic              dbg_blk_i,
  input  logic              consume_i,
  input  logic              hold_i,
  output logic [TRAP_W-1:0] eff_o,
  output logic [TRAP_W-1:0] next_o,
  output logic [TRAP_W-1:0] word_o
);
  localparam int SS_BIT = TRAP_W - 2;
  localparam logic [TRAP_W-1:0] SS_MASK = TRAP_W'(1) << SS_BIT;

  logic [TRAP_W-1:0] word_q, word_d, raw, base;

  always_comb begin
    raw   = word_q | hit_i;
    eff_o = gate_i ? raw : (raw & SS_MASK);
    if (consume_i)               base = '0;
    else if (hold_i | dbg_blk_i) base = eff_o;
    else                         base = '0;
    next_o = base | ((tf_i & ~consume_i & ~hold_i) ? SS_MASK : '0);
    word_d = bnd_i ? next_o : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;

  // R9
  gate_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_i && !gate_i) |=> ((word_q & ~SS_MASK) == '0));
endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
  parameter int N = 9
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] sel_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign sel_o[k]    = req_i[k] & ~seen[k];
    assign seen[k + 1] = seen[k] | req_i[k];
  end
endmodule

// File: rtl/evt_boundary_arb.sv
module evt_boundary_arb #(
  parameter int TRAP_W  = 16,
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_i,
  input  logic              gate_i,
  input  logic              if_i,
  input  logic              tf_i,
  input  logic              smi_pend_i,
  input  logic              smi_mask_i,
  input  logic              init_pend_i,
  input  logic              init_mask_i,
  input  logic              nmi_pend_i,
  input  logic              nmi_mask_i,
  input  logic              lint_pend_i,
  input  logic              ext_pend_i,
  input  logic              virt_pend_i,
  input  logic              dma_req_i,
  input  logic [TRAP_W-1:0] trap_hit_i,
  input  logic              shd_load_i,
  input  logic [1:0]        shd_cat_i,
  input  logic              shd_ss_i,
  output logic [8:0]        gnt_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              smi_clr_o,
  output logic              nmi_clr_o,
  output logic              nmi_mask_set_o,
  output logic              pend_o,
  output logic [TRAP_W-1:0] trap_word_o
);
  import evt_arb_pkg::*;

  localparam int TS_BIT = TRAP_W - 1;
  localparam int NIB_LO = TRAP_W - 4;
  localparam int NSRC   = 6;

  logic              int_blk, dbg_blk, ext_ok;
  logic [TRAP_W-1:0] eff, nxt_word;
  logic [NGRP-1:0]   req, sel;
  logic [NSRC-1:0]   unm, srv;
  logic              consume, hold, pend_calc;

  logic [NGRP-1:0]   gnt_q, gnt_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic              smi_clr_q, smi_clr_d;
  logic              nmi_clr_q, nmi_clr_d;
  logic              nmi_msk_q, nmi_msk_d;
  logic              pend_q, pend_d;

  evt_shadow_trk i_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .bnd_i     (bnd_i),
    .load_i    (shd_load_i),
    .cat_i     (shd_cat_i),
    .ss_i      (shd_ss_i),
    .int_blk_o (int_blk),
    .dbg_blk_o (dbg_blk)
  );

  evt_trap_word #(.TRAP_W(TRAP_W)) i_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .bnd_i     (bnd_i),
    .hit_i     (trap_hit_i),
    .gate_i    (gate_i),
    .tf_i      (tf_i),
    .dbg_blk_i (dbg_blk),
    .consume_i (consume),
    .hold_i    (hold),
    .eff_o     (eff),
    .next_o    (nxt_word),
    .word_o    (trap_word_o)
  );

  // candidate groups
  always_comb begin
    ext_ok       = gate_i & ~int_blk;
    req          = '0;
    req[G_TSW]   = eff[TS_BIT];
    req[G_SMI]   = gate_i & smi_pend_i & ~smi_mask_i;
    req[G_INIT]  = gate_i & init_pend_i & ~init_mask_i;
    req[G_DBG]   = ~dbg_blk & (|eff[TS_BIT-1:NIB_LO]);
    req[G_NMI]   = ext_ok & nmi_pend_i & ~nmi_mask_i;
    req[G_LINT]  = ext_ok & if_i & lint_pend_i;
    req[G_EXT]   = ext_ok & if_i & ext_pend_i;
    req[G_VIRT]  = ext_ok & virt_pend_i;
    req[G_DMA]   = ext_ok & dma_req_i;
  end

  evt_prio_pick #(.N(NGRP)) i_pick (
    .req_i (req),
    .sel_o (sel)
  );

  // summary of what remains after this boundary
  always_comb begin
    consume   = sel[G_TSW] | sel[G_DBG];
    hold      = sel[G_SMI] | sel[G_INIT];
    unm       = {virt_pend_i, if_i & ext_pend_i, if_i & lint_pend_i,
                 nmi_pend_i & ~nmi_mask_i, init_pend_i & ~init_mask_i,
                 smi_pend_i & ~smi_mask_i};
    srv       = {sel[G_VIRT], sel[G_EXT], sel[G_LINT],
                 sel[G_NMI], sel[G_INIT], sel[G_SMI]};
    pend_calc = (|nxt_word) | dma_req_i | (gate_i & (|(unm & ~srv)));
  end

  // next-state
  always_comb begin
    gnt_d     = '0;
    vec_d     = '0;
    smi_clr_d = 1'b0;
    nmi_clr_d = 1'b0;
    nmi_msk_d = 1'b0;
    pend_d    = pend_q;
    if (bnd_i) begin
      gnt_d     = sel;
      vec_d     = sel[G_NMI] ? VEC_W'(NMI_VEC) : '0;
      smi_clr_d = sel[G_SMI];
      nmi_clr_d = sel[G_NMI];
      nmi_msk_d = sel[G_NMI];
      pend_d    = pend_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q     <= '0;
      vec_q     <= '0;
      smi_clr_q <= 1'b0;
      nmi_clr_q <= 1'b0;
      nmi_msk_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      gnt_q     <= gnt_d;
      vec_q     <= vec_d;
      smi_clr_q <= smi_clr_d;
      nmi_clr_q <= nmi_clr_d;
      nmi_msk_q <= nmi_msk_d;
      pend_q    <= pend_d;
    end
  end

  assign gnt_o          = gnt_q;
  assign vec_o          = vec_q;
  assign smi_clr_o      = smi_clr_q;
  assign nmi_clr_o      = nmi_clr_q;
  assign nmi_mask_set_o = nmi_msk_q;
  assign pend_o         = pend_q;

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R2
  gnt_needs_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd_i |=> (gnt_q == '0) && !nmi_clr_q && !smi_clr_q);

  // R4
  gate_smi_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_i && !gate_i) |=> !gnt_q[G_SMI] && !gnt_q[G_INIT]);

  // R5
  nmi_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_i && nmi_mask_i) |=> !gnt_q[G_NMI]);

  // R7
  shadow_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_i && int_blk) |=> (gnt_q[G_DMA:G_NMI] == '0));
endmodule

// File: tb/test_evt_boundary_arb.sv
module test_evt_boundary_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd = 1'b0;
  logic        gate, ifl, tf;
  logic        smi_p, smi_m, init_p, init_m, nmi_p, nmi_m;
  logic        lint, ext, virt, dma;
  logic [15:0] hit;
  logic        shd_load, shd_ss;
  logic [1:0]  shd_cat;
  logic [8:0]  gnt;
  logic [7:0]  vec;
  logic        smi_clr, nmi_clr, nmi_mset, pend;
  logic [15:0] tword;

  int total = 0;
  int bad = 0;

  logic [15:0] m_word = 16'h0;
  logic        m_prev_ss = 1'b0;

  always #2 clk = ~clk;

  evt_boundary_arb i_evt_boundary_arb (
    .clk(clk), .rst_n(rst_n), .bnd_i(bnd), .gate_i(gate), .if_i(ifl),
    .tf_i(tf), .smi_pend_i(smi_p), .smi_mask_i(smi_m),
    .init_pend_i(init_p), .init_mask_i(init_m), .nmi_pend_i(nmi_p),
    .nmi_mask_i(nmi_m), .lint_pend_i(lint), .ext_pend_i(ext),
    .virt_pend_i(virt), .dma_req_i(dma), .trap_hit_i(hit),
    .shd_load_i(shd_load), .shd_cat_i(shd_cat), .shd_ss_i(shd_ss),
    .gnt_o(gnt), .vec_o(vec), .smi_clr_o(smi_clr), .nmi_clr_o(nmi_clr),
    .nmi_mask_set_o(nmi_mset), .pend_o(pend), .trap_word_o(tword)
  );

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    gate = 1; ifl = 0; tf = 0;
    smi_p = 0; smi_m = 0; init_p = 0; init_m = 0; nmi_p = 0; nmi_m = 0;
    lint = 0; ext = 0; virt = 0; dma = 0; hit = 16'h0;
    shd_load = 0; shd_cat = 2'b00; shd_ss = 0;
  endtask

  // Reference computed from the requirements; inputs set at a negedge.
  task automatic step(string tag);
    logic [15:0] wr, w, wn;
    logic armed, ib, db, ok, cons, hold, p, found;
    logic [8:0] req, g;
    logic [5:0] unm, srv;
    armed = shd_load && !(shd_ss && m_prev_ss);
    ib = armed & shd_cat[0];
    db = armed & shd_cat[1];
    wr = m_word | hit;
    w  = gate ? wr : (wr & 16'h4000);
    ok = gate & !ib;
    req[0] = w[15];
    req[1] = gate & smi_p & !smi_m;
    req[2] = gate & init_p & !init_m;
    req[3] = !db && (w[14:12] != 3'b000);
    req[4] = ok & nmi_p & !nmi_m;
    req[5] = ok & ifl & lint;
    req[6] = ok & ifl & ext;
    req[7] = ok & virt;
    req[8] = ok & dma;
    g = 9'h0; found = 0;
    for (int k = 0; k < 9; k++) begin
      if (req[k] && !found) begin g[k] = 1'b1; found = 1; end
    end
    cons = g[0] | g[3];
    hold = g[1] | g[2];
    wn = cons ? 16'h0 : ((hold | db) ? w : 16'h0);
    if (tf && !cons && !hold) wn = wn | 16'h4000;
    unm = {virt, ifl & ext, ifl & lint, nmi_p & !nmi_m, init_p & !init_m, smi_p & !smi_m};
    srv = {g[7], g[6], g[5], g[4], g[2], g[1]};
    p = (wn != 16'h0) | dma | (gate && ((unm & ~srv) != 6'h0));
    bnd = 1;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "grant", 32'(gnt), 32'(g));
    chk(tag, "vector", 32'(vec), g[4] ? 32'd2 : 32'd0);
    chk(tag, "pulses", {29'h0, smi_clr, nmi_clr, nmi_mset}, {29'h0, g[1], g[4], g[4]});
    chk(tag, "trapword", 32'(tword), 32'(wn));
    chk(tag, "pending", 32'(pend), 32'(p));
    m_word = wn;
    m_prev_ss = armed & shd_ss;
    bnd = 0;
    @(posedge clk);
    @(negedge clk);
    // R2: nothing is granted without a preceding strobe
    chk("R2", "idle grant", {20'h0, gnt, smi_clr, nmi_clr, nmi_mset}, 32'h0);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset outputs", {gnt, vec, smi_clr, nmi_clr, nmi_mset, pend, 12'h0}, 32'h0);
    chk("R1", "reset word", 32'(tword), 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "post-reset", {gnt, vec, pend, 14'h0}, 32'h0);

    // R4
    idle(); gate = 0; smi_p = 1; step("R4");
    idle(); smi_p = 1; init_p = 1; step("R4");
    idle(); init_p = 1; step("R4");
    idle(); init_p = 1; init_m = 1; step("R4");
    // R5
    idle(); nmi_p = 1; ext = 1; ifl = 1; step("R5");
    idle(); nmi_p = 1; nmi_m = 1; step("R5");
    // R6
    idle(); lint = 1; ext = 1; ifl = 1; step("R6");
    idle(); lint = 1; ext = 1; step("R6");
    idle(); ext = 1; ifl = 1; step("R6");
    // R7
    idle(); ext = 1; ifl = 1; shd_load = 1; shd_cat = 2'b01; step("R7");
    idle(); ext = 1; ifl = 1; step("R7");
    idle(); dma = 1; gate = 0; step("R7");
    // R8
    idle(); ext = 1; ifl = 1; shd_load = 1; shd_cat = 2'b11; shd_ss = 1; step("R8");
    idle(); ext = 1; ifl = 1; shd_load = 1; shd_cat = 2'b11; shd_ss = 1; step("R8");
    idle(); ext = 1; ifl = 1; shd_load = 1; shd_cat = 2'b11; shd_ss = 1; step("R8");
    idle(); step("R8");
    // R9
    idle(); gate = 0; hit = 16'hA003; step("R9");
    idle(); gate = 0; hit = 16'h4000; step("R9");
    // R10
    idle(); tf = 1; step("R10");
    idle(); step("R10");
    idle(); tf = 1; smi_p = 1; step("R10");
    // R11
    idle(); hit = 16'h0005; step("R11");
    idle(); hit = 16'h8000; step("R11");
    idle(); hit = 16'h1000; shd_load = 1; shd_cat = 2'b10; step("R11");
    idle(); step("R11");
    idle(); hit = 16'h2000; init_p = 1; step("R11");
    idle(); step("R11");
    // R12
    idle(); dma = 1; step("R12");
    idle(); step("R12");
    idle(); nmi_p = 1; nmi_m = 1; step("R12");
    idle(); ext = 1; step("R12");
    idle(); virt = 1; step("R12");
    idle(); virt = 1; shd_load = 1; shd_cat = 2'b01; step("R12");
    idle(); smi_p = 1; nmi_p = 1; step("R12");

    // R3: sweep of every flag combination with hashed trap and shadow stimulus
    for (int i = 0; i < 16384; i++) begin
      logic [31:0] h;
      h = (i * 37) ^ (i >> 5);
      smi_p = i[0]; smi_m = i[1]; init_p = i[2]; init_m = i[3];
      nmi_p = i[4]; nmi_m = i[5]; lint = i[6]; ext = i[7]; virt = i[8];
      dma = i[9]; ifl = i[10]; gate = i[11]; tf = i[12]; shd_load = i[13];
      shd_cat = h[1:0]; shd_ss = h[2];
      case (h[6:3])
        4'd3:    hit = 16'h8000;
        4'd5:    hit = 16'h2001;
        4'd9:    hit = 16'h0003;
        4'd12:   hit = 16'h1000;
        default: hit = 16'h0000;
      endcase
      step("R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule